// File: doc/BRIEF.md
# Half-Duplex Command and Response Queue

This block carries all traffic between a host processor and a command processor through a single byte queue that works in one direction at a time. In write mode the host stores bytes by strobing either a command address or a parameter address. Each stored entry keeps a tag bit that records which address was used. The command processor takes entries from a valid/ready port, sees the tag next to each byte, and decodes the opcodes itself.

When the command processor has interpreted a command that needs an answer, it pulses a turnaround input. Everything still queued is then thrown away and the queue switches to read mode. In read mode the processor pushes response bytes. Each byte moves through a host data register, and a ready flag tells the host when a byte can be read.

A command written by the host at any time ends a read sequence. The unread bytes are lost, and the queue returns to write mode holding only that command. Status outputs report ready, full, empty and a sticky overflow.

Top module: `hdfifo`

## Requirements
- R1: After reset the queue is in write mode with statEmpty=1, statFull=0, statReady=0, statOverflow=0, procValid=0 and procPushReady=0.
- R2: In write mode, host bytes leave through procData in the order they were written. procIsCmd is 1 for a byte written with hostCmdWr and 0 for one written with hostParWr. procValid is 1 whenever an entry is queued, and an entry is removed in a cycle where procValid and procReady are both 1.
- R3: statFull is 1 when DEPTH (16) entries are queued. A host write made while statFull is 1 in write mode is dropped and sets statOverflow, which then stays 1 until reset.
- R4: A procTurn pulse in write mode discards every queued entry and any host write in the same cycle. From the next cycle the queue is in read mode and empty.
- R5: In read mode, procPushReady is 1 while the buffer is not full, and a byte offered with procPushValid is stored only then. Host parameter writes are ignored. procValid stays 0.
- R6: In read mode, when the host register is empty and a byte is buffered, that byte moves into hostRdData and statReady becomes 1 on the next cycle. A hostRd while statReady is 1 consumes it, and statReady is then 0 for at least one cycle.
- R7: A hostCmdWr in read mode discards the buffered bytes and the host register byte. The queue returns to write mode with that command as its only entry, tagged as a command.
- R8: When hostCmdWr and hostParWr are strobed together, only the command is stored.
- R9: statEmpty is 1 exactly when no entry is held in the buffer; the host data register does not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostCmdWr | input | 1 | Host write strobe, command address |
| hostParWr | input | 1 | Host write strobe, parameter address |
| hostWrData | input | DATA_W | Host write byte |
| hostRd | input | 1 | Host read strobe for the data register |
| hostRdData | output | DATA_W | Host data register |
| statReady | output | 1 | Byte available in hostRdData |
| statFull | output | 1 | Buffer holds DEPTH entries |
| statEmpty | output | 1 | Buffer holds no entry |
| statOverflow | output | 1 | Sticky: a host write was dropped on full |
| procValid | output | 1 | Entry available to the command processor |
| procIsCmd | output | 1 | Tag of the head entry: 1 = command |
| procData | output | DATA_W | Byte of the head entry |
| procReady | input | 1 | Command processor takes the head entry |
| procTurn | input | 1 | Turn the queue to read mode, discarding entries |
| procPushValid | input | 1 | Response byte offered |
| procPushData | input | DATA_W | Response byte |
| procPushReady | output | 1 | Response byte accepted this cycle |

## Verification
The bench builds the block with its defaults, DEPTH=16 and DATA_W=8. The buffer can therefore be filled in a few dozen cycles, which puts the full edge, the dropped write, the overflow flag and the full-buffer push stall within reach of both directed and random traffic. A behavioural queue model is compared with every output on each clock. It runs through turnarounds in both directions with buffered data still present, simultaneous strobes, and read sequences cut short by commands.

// File: rtl/hdfifo_pkg.sv
package hdfifo_pkg;
  // strobes from the control to the datapath, one cycle each
  typedef struct packed {
    logic flush;     // empty the buffer before any push of this cycle
    logic push;      // store one entry
    logic pushHost;  // 1: entry from host port, 0: from processor push port
    logic pushTag;   // tag stored with a host entry (1 = command)
    logic pop;       // remove the head entry
    logic loadOut;   // copy head byte into the host data register
    logic clrOut;    // host data register becomes empty
  } fifoCtl_t;
endpackage

// File: rtl/hdfifo_dpath.sv
module hdfifo_dpath
  import hdfifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoCtl_t          ctl,
  input  logic [DATA_W-1:0] hostData,
  input  logic [DATA_W-1:0] pushData,
  output logic              headTag,
  output logic [DATA_W-1:0] headData,
  output logic              full,
  output logic              empty,
  output logic              outValid,
  output logic [DATA_W-1:0] outData
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = DATA_W + 1;

  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr, wrIdx;
  logic [CW-1:0] count;
  logic [EW-1:0] entry;

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign entry   = ctl.pushHost ? {ctl.pushTag, hostData} : {1'b0, pushData};
  assign wrIdx   = ctl.flush ? '0 : wrPtr;
  assign headTag  = mem[rdPtr][EW-1];
  assign headData = mem[rdPtr][DATA_W-1:0];
  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);

  always_ff @(posedge clk) begin
    if (ctl.push) mem[wrIdx] <= entry;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (ctl.flush) begin
      rdPtr <= '0;
      wrPtr <= ctl.push ? nextPtr('0) : '0;
      count <= ctl.push ? CW'(1) : '0;
    end else begin
      if (ctl.push) wrPtr <= nextPtr(wrPtr);
      if (ctl.pop)  rdPtr <= nextPtr(rdPtr);
      case ({ctl.push, ctl.pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      if (ctl.clrOut)       outValid <= 1'b0;
      else if (ctl.loadOut) outValid <= 1'b1;
      if (ctl.loadOut)      outData  <= headData;
    end
  end
endmodule

// File: rtl/hdfifo_ctrl.sv
module hdfifo_ctrl
  import hdfifo_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     hostCmdWr,
  input  logic     hostParWr,
  input  logic     hostRd,
  input  logic     procReady,
  input  logic     procTurn,
  input  logic     procPushValid,
  input  logic     full,
  input  logic     empty,
  input  logic     outValid,
  output fifoCtl_t ctl,
  output logic     readMode,
  output logic     overflow,
  output logic     procValid,
  output logic     procPushReady
);
  logic cmdW, parW, turnNow, backNow, wrDrop;

  assign cmdW    = hostCmdWr;
  assign parW    = hostParWr & ~hostCmdWr;
  assign turnNow = procTurn & ~readMode;
  assign backNow = hostCmdWr & readMode;

  assign procValid     = ~readMode & ~empty;
  assign procPushReady = readMode & ~full;

  always_comb begin
    ctl    = '0;
    wrDrop = 1'b0;
    if (turnNow) begin
      ctl.flush = 1'b1;
    end else if (backNow) begin
      ctl.flush    = 1'b1;
      ctl.clrOut   = 1'b1;
      ctl.push     = 1'b1;
      ctl.pushHost = 1'b1;
      ctl.pushTag  = 1'b1;
    end else if (!readMode) begin
      ctl.pop = procValid & procReady;
      if (cmdW | parW) begin
        if (full) begin
          wrDrop = 1'b1;
        end else begin
          ctl.push     = 1'b1;
          ctl.pushHost = 1'b1;
          ctl.pushTag  = cmdW;
        end
      end
    end else begin
      ctl.loadOut = ~outValid & ~empty;
      ctl.pop     = ctl.loadOut;
      ctl.clrOut  = hostRd & outValid;
      ctl.push    = procPushValid & procPushReady;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readMode <= 1'b0;
      overflow <= 1'b0;
    end else begin
      if (turnNow)      readMode <= 1'b1;
      else if (backNow) readMode <= 1'b0;
      if (wrDrop)       overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/hdfifo.sv
module hdfifo
  import hdfifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostCmdWr,
  input  logic              hostParWr,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              hostRd,
  output logic [DATA_W-1:0] hostRdData,
  output logic              statReady,
  output logic              statFull,
  output logic              statEmpty,
  output logic              statOverflow,
  output logic              procValid,
  output logic              procIsCmd,
  output logic [DATA_W-1:0] procData,
  input  logic              procReady,
  input  logic              procTurn,
  input  logic              procPushValid,
  input  logic [DATA_W-1:0] procPushData,
  output logic              procPushReady
);
  fifoCtl_t ctl;
  logic     readMode;

  hdfifo_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .hostCmdWr(hostCmdWr), .hostParWr(hostParWr), .hostRd(hostRd),
    .procReady(procReady), .procTurn(procTurn), .procPushValid(procPushValid),
    .full(statFull), .empty(statEmpty), .outValid(statReady),
    .ctl(ctl), .readMode(readMode), .overflow(statOverflow),
    .procValid(procValid), .procPushReady(procPushReady)
  );

  hdfifo_dpath #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .hostData(hostWrData), .pushData(procPushData),
    .headTag(procIsCmd), .headData(procData),
    .full(statFull), .empty(statEmpty),
    .outValid(statReady), .outData(hostRdData)
  );
endmodule

// File: rtl/hdfifo_chk.sv
module hdfifo_chk (
  input logic clk,
  input logic rstN,
  input logic hostCmdWr,
  input logic hostParWr,
  input logic hostRd,
  input logic procTurn,
  input logic readMode,
  input logic statReady,
  input logic statFull,
  input logic statEmpty,
  input logic statOverflow,
  input logic procValid,
  input logic procIsCmd,
  input logic procPushReady
);
  assert_ovf_sets_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!readMode && statFull && hostParWr && !hostCmdWr && !procTurn) |=> statOverflow);

  assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    statOverflow |=> statOverflow);

  assert_turn_flush_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!readMode && procTurn) |=> (statEmpty && readMode && !procValid));

  assert_cmd_back_R7: assert property (@(posedge clk) disable iff (!rstN)
    (readMode && hostCmdWr) |=> (!readMode && procValid && procIsCmd && !statReady));

  assert_ready_gap_R6: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && statReady) |=> !statReady);

  assert_one_way_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(procValid && procPushReady));

  assert_no_ready_in_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    !readMode |-> !statReady);

  assert_flags_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(statFull && statEmpty));
endmodule

bind hdfifo hdfifo_chk u_chk (
  .clk(clk), .rstN(rstN), .hostCmdWr(hostCmdWr), .hostParWr(hostParWr),
  .hostRd(hostRd), .procTurn(procTurn), .readMode(readMode),
  .statReady(statReady), .statFull(statFull), .statEmpty(statEmpty),
  .statOverflow(statOverflow), .procValid(procValid), .procIsCmd(procIsCmd),
  .procPushReady(procPushReady)
);

// File: tb/hdfifo_bench.sv
`timescale 1ns/1ps
module hdfifo_bench;
  localparam int DEPTH  = 16;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostCmdWr = 0, hostParWr = 0, hostRd = 0;
  logic procReady = 0, procTurn = 0, procPushValid = 0;
  logic [DATA_W-1:0] hostWrData = '0, procPushData = '0;
  logic [DATA_W-1:0] hostRdData, procData;
  logic statReady, statFull, statEmpty, statOverflow, procValid, procIsCmd, procPushReady;

  always #4 clk = ~clk;

  hdfifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_hdfifo (
    .clk(clk), .rstN(rstN), .hostCmdWr(hostCmdWr), .hostParWr(hostParWr),
    .hostWrData(hostWrData), .hostRd(hostRd), .hostRdData(hostRdData),
    .statReady(statReady), .statFull(statFull), .statEmpty(statEmpty),
    .statOverflow(statOverflow), .procValid(procValid), .procIsCmd(procIsCmd),
    .procData(procData), .procReady(procReady), .procTurn(procTurn),
    .procPushValid(procPushValid), .procPushData(procPushData),
    .procPushReady(procPushReady)
  );

  int nChk = 0, nBad = 0;
  bit done = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  endtask

  // behavioural model
  logic [8:0] q[$];
  bit mRead = 0, mOutV = 0, mOvf = 0;
  logic [7:0] mOut = '0;

  always @(posedge clk) begin
    if (!rstN) begin
      q.delete(); mRead = 0; mOutV = 0; mOvf = 0;
    end else begin
      bit cmdW, parW, wasFull, rdNow, loadNow, pushNow;
      cmdW = hostCmdWr;
      parW = hostParWr && !hostCmdWr;
      wasFull = (q.size() == DEPTH);
      if (!mRead && procTurn) begin
        q.delete(); mRead = 1;
      end else if (mRead && cmdW) begin
        q.delete(); mOutV = 0; mRead = 0;
        q.push_back({1'b1, hostWrData});
      end else if (!mRead) begin
        if (q.size() > 0 && procReady) void'(q.pop_front());
        if (cmdW || parW) begin
          if (wasFull) mOvf = 1;
          else q.push_back({cmdW, hostWrData});
        end
      end else begin
        rdNow   = hostRd && mOutV;
        loadNow = !mOutV && q.size() > 0;
        pushNow = procPushValid && !wasFull;
        if (loadNow) begin
          mOut = q[0][7:0]; void'(q.pop_front()); mOutV = 1;
        end
        if (rdNow) mOutV = 0;
        if (pushNow) q.push_back({1'b0, procPushData});
      end
    end
  end

  // compare all outputs every cycle, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R9", "statEmpty", statEmpty, q.size() == 0);
      chk("R3", "statFull", statFull, q.size() == DEPTH);
      chk("R3", "statOverflow", statOverflow, mOvf);
      chk("R2", "procValid", procValid, !mRead && q.size() > 0);
      chk("R5", "procPushReady", procPushReady, mRead && q.size() < DEPTH);
      chk("R6", "statReady", statReady, mOutV);
      if (mOutV) chk("R6", "hostRdData", hostRdData, mOut);
      if (!mRead && q.size() > 0) begin
        chk("R2", "procIsCmd", procIsCmd, q[0][8]);
        chk("R2", "procData", procData, q[0][7:0]);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    finishRun();
  end

  task automatic idle();
    hostCmdWr = 0; hostParWr = 0; hostRd = 0;
    procReady = 0; procTurn = 0; procPushValid = 0;
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    chk("R1", "statEmpty", statEmpty, 1);
    chk("R1", "statFull", statFull, 0);
    chk("R1", "statReady", statReady, 0);
    chk("R1", "statOverflow", statOverflow, 0);
    chk("R1", "procValid", procValid, 0);
    chk("R1", "procPushReady", procPushReady, 0);

    // R2: a command and three parameters, then drain
    @(negedge clk); hostCmdWr = 1; hostWrData = 8'hA1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); hostCmdWr = 0; hostParWr = 1; hostWrData = 8'h10 + 8'(i);
    end
    @(negedge clk); idle(); #1;
    chk("R2", "head is command", {procValid, procIsCmd, procData}, {2'b11, 8'hA1});
    procReady = 1;
    repeat (4) @(negedge clk);
    procReady = 0; #1;
    chk("R9", "drained empty", statEmpty, 1);

    // R3: fill and overflow
    for (int i = 0; i < DEPTH + 1; i++) begin
      @(negedge clk); hostParWr = 1; hostWrData = 8'(i);
    end
    @(negedge clk); idle(); #1;
    chk("R3", "full after fill", statFull, 1);
    chk("R3", "overflow set", statOverflow, 1);

    // R4: turnaround with queued entries and a concurrent host write
    @(negedge clk); procReady = 1; procTurn = 1; hostParWr = 1; hostWrData = 8'h77;
    @(negedge clk); idle(); #1;
    chk("R4", "empty after turn", statEmpty, 1);
    chk("R4", "read mode", procPushReady, 1);

    // R5: pushes with parameter writes ignored, until buffer full
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); procPushValid = 1; procPushData = 8'h40 + 8'(i);
      hostParWr = i[0]; hostWrData = 8'hEE;
    end
    @(negedge clk); idle(); #1;
    chk("R5", "push stalls on full", procPushReady, 0);
    chk("R6", "first response", {statReady, hostRdData}, {1'b1, 8'h40});

    // R6: read gap then next byte
    @(negedge clk); hostRd = 1;
    @(negedge clk); idle(); #1;
    chk("R6", "ready drops", statReady, 0);
    @(negedge clk); #1;
    chk("R6", "next response", {statReady, hostRdData}, {1'b1, 8'h41});

    // R7: command ends the read sequence
    @(negedge clk); hostCmdWr = 1; hostWrData = 8'hC3;
    @(negedge clk); idle(); #1;
    chk("R7", "back to write", {procValid, procIsCmd, procData, statReady}, {2'b11, 8'hC3, 1'b0});

    // R8: both strobes at once
    @(negedge clk); procReady = 1;
    @(negedge clk); procReady = 0; hostCmdWr = 1; hostParWr = 1; hostWrData = 8'h5C;
    @(negedge clk); idle(); procReady = 1; #1;
    chk("R8", "single command", {procValid, procIsCmd, procData}, {2'b11, 8'h5C});
    @(negedge clk); idle(); #1;
    chk("R8", "only one entry", statEmpty, 1);

    // random traffic in phases of different drain pressure
    for (int ph = 0; ph < 8; ph++) begin
      for (int c = 0; c < 400; c++) begin
        @(negedge clk);
        hostCmdWr     = ($urandom % 30) == 0;
        hostParWr     = ($urandom % 2) == 0;
        hostWrData    = 8'($urandom);
        procReady     = ($urandom % 8) < ph;
        procTurn      = ($urandom % 20) == 0;
        procPushValid = ($urandom % 2) == 0;
        procPushData  = 8'($urandom);
        hostRd        = ($urandom % 8) < (8 - ph);
      end
    end
    @(negedge clk); idle();
    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule